// File: doc/BRIEF.md
# Variable-Step Nonlinear Filter Generator

This block produces the keystream of a clock-controlled stream cipher. A 127-stage linear feedback shift register holds the secret state. On every running cycle it jumps ahead by one, two, three or four positions, as a 2-bit step input commands. A neighbouring clock-control unit supplies that input. Twelve fixed stages of the register form a 12-bit address into a 4096-entry, one-bit-wide table that holds a nonlinear Boolean function. The table output is the keystream bit.

A single cycle may require a jump of four positions. For this reason all four advanced copies of the state are formed side by side. The tap bits of every copy are registered, and a bank of twelve 4-to-1 selectors then picks the copy that matches the registered step count. This balances the delay through the datapath. A parallel load replaces the state and empties the pipeline. A small controller with the states IDLE, FILL and RUN qualifies the output. IDLE goes to FILL when run is sampled high without load. FILL goes to RUN once the pipeline has refilled. RUN and FILL both return to IDLE when run is low or load is high, and load always forces IDLE.

Top module: `varstep_filter_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, ks_valid_o and ks_bit_o are 0.
- R2: One step of the register moves each stage s[i+1] into s[i] and places s[0] XOR s[1] into stage 126.
- R3: When run_i is 1 and load_i is 0, the state advances at the clock edge by step_sel_i + 1 steps (00 = 1, 01 = 2, 10 = 3, 11 = 4).
- R4: The filter address bit i is the register stage at position i of the list 3, 11, 19, 28, 37, 47, 58, 69, 80, 92, 104, 118, with bit 0 as the least significant bit.
- R5: ks_bit_o after edge e+1 is the filter value of the state that stood after edge e.
- R6: ks_valid_o rises after the second consecutive edge at which run_i=1 and load_i=0. It stays high while that holds, and it is 0 after any edge at which run_i=0.
- R7: When run_i is 0 and load_i is 0, the state is held unchanged.
- R8: When load_i is 1, the state becomes load_state_i at the edge with no advance, even if run_i is 1. ks_valid_o is 0 after that edge, and refilling restarts as in R6.
- R9: The table entry for address a is a0^a3^a6^a10 ^ (a1&a4) ^ (a2&a8&a11) ^ (a5&a7) ^ (a9&~a6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Advance the state and produce keystream |
| step_sel_i | input | 2 | Step count minus one |
| load_i | input | 1 | Replace the state and flush the pipeline |
| load_state_i | input | 127 | New state value |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is valid |

## Verification
A load request and a run request with an active step count can fall in the same cycle. In that case the load must win, and the step must be dropped completely. The bench raises load together with run and a 4-step command at several points: in the middle of a stream, during FILL, and on back-to-back cycles. It then lets the stream refill. The bench judges the outcome from the output alone. Every keystream bit after the refill must equal the filter of the loaded state, advanced only by the steps that came after the load. ks_valid_o must also stay low for exactly the refill time.

// File: rtl/vsf_pkg.sv
`timescale 1ns/1ps
package vsf_pkg;

    localparam int STATE_W    = 127;
    localparam int NUM_COPIES = 4;
    localparam int NUM_TAPS   = 12;
    localparam int SEL_W      = $clog2(NUM_COPIES);
    localparam int ROM_DEPTH  = 1 << NUM_TAPS;
    localparam int FB_LO      = 0;
    localparam int FB_HI      = 1;
    localparam int PIPE_LAT   = 2;

    typedef logic [STATE_W-1:0]  state_t;
    typedef logic [NUM_TAPS-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    localparam int TAP_POS [NUM_TAPS] = '{3, 11, 19, 28, 37, 47, 58, 69, 80, 92, 104, 118};

    // one shift of the register, feedback entering at the top stage
    function automatic state_t advance_one(input state_t s);
        return {s[FB_LO] ^ s[FB_HI], s[STATE_W-1:1]};
    endfunction

    function automatic addr_t gather_taps(input state_t s);
        addr_t a;
        for (int i = 0; i < NUM_TAPS; i++) begin
            a[i] = s[TAP_POS[i]];
        end
        return a;
    endfunction

    function automatic logic filter_eq(input addr_t a);
        return a[0] ^ a[3] ^ a[6] ^ a[10]
             ^ (a[1] & a[4])
             ^ (a[2] & a[8] & a[11])
             ^ (a[5] & a[7])
             ^ (a[9] & ~a[6]);
    endfunction

    function automatic logic [ROM_DEPTH-1:0] build_table();
        logic [ROM_DEPTH-1:0] t;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            t[i] = filter_eq(addr_t'(i));
        end
        return t;
    endfunction

endpackage

// File: rtl/vsf_jump_chain.sv
`timescale 1ns/1ps
module vsf_jump_chain
    import vsf_pkg::*;
#(
    parameter int COPIES = NUM_COPIES
) (
    input  state_t                         base_i,
    output logic [COPIES-1:0][STATE_W-1:0] copies_o
);

    // copy k holds the base advanced by k+1 steps
    genvar k;
    generate
        for (k = 0; k < COPIES; k++) begin : g_copy
            if (k == 0) begin : g_first
                assign copies_o[k] = advance_one(base_i);
            end else begin : g_next
                assign copies_o[k] = advance_one(copies_o[k-1]);
            end
        end
    endgenerate

endmodule

// File: rtl/vsf_tap_pipe.sv
`timescale 1ns/1ps
module vsf_tap_pipe
    import vsf_pkg::*;
#(
    parameter int COPIES = NUM_COPIES,
    localparam int SW    = $clog2(COPIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [COPIES-1:0][STATE_W-1:0] copies_i,
    input  logic [SW-1:0]                  sel_i,
    output addr_t                          addr_o
);

    logic [COPIES-1:0][NUM_TAPS-1:0] taps_q;
    logic [SW-1:0]                   sel_q;

    // balancing registers: tap subset of every copy, plus the step count
    genvar k;
    generate
        for (k = 0; k < COPIES; k++) begin : g_taps
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    taps_q[k] <= '0;
                end else begin
                    taps_q[k] <= gather_taps(copies_i[k]);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_i;
        end
    end

    // one 4-to-1 selector per filter input
    genvar b;
    generate
        for (b = 0; b < NUM_TAPS; b++) begin : g_mux
            always_comb begin
                addr_o[b] = taps_q[sel_q][b];
            end
        end
    endgenerate

endmodule

// File: rtl/vsf_filter_rom.sv
`timescale 1ns/1ps
module vsf_filter_rom
    import vsf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t addr_i,
    output logic  bit_o
);

    localparam logic [ROM_DEPTH-1:0] TABLE = build_table();

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
        end else begin
            bit_o <= TABLE[addr_i];
        end
    end

endmodule

// File: rtl/vsf_ctrl.sv
`timescale 1ns/1ps
module vsf_ctrl
    import vsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic load_i,
    output logic valid_o
);

    localparam int FILL_CYC = PIPE_LAT - 1;
    localparam int CNT_W    = (FILL_CYC > 1) ? $clog2(FILL_CYC) : 1;

    gen_state_e       state_q, state_d;
    logic [CNT_W-1:0] fill_q;
    logic             fill_done;

    assign fill_done = (fill_q == CNT_W'(FILL_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_d != ST_FILL || state_q != ST_FILL) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i && !load_i) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (load_i || !run_i) state_d = ST_IDLE;
                else if (fill_done)   state_d = ST_RUN;
            end
            ST_RUN: begin
                if (load_i || !run_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        valid_o = (state_q == ST_RUN);
    end

endmodule

// File: rtl/varstep_filter_gen.sv
`timescale 1ns/1ps
module varstep_filter_gen
    import vsf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [1:0]   step_sel_i,
    input  logic         load_i,
    input  logic [126:0] load_state_i,
    output logic         ks_bit_o,
    output logic         ks_valid_o
);

    state_t                             base_q;
    logic [NUM_COPIES-1:0][STATE_W-1:0] copies;
    addr_t                              rom_addr;

    vsf_jump_chain #(.COPIES(NUM_COPIES)) u_chain (
        .base_i   (base_q),
        .copies_o (copies)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= state_t'(1);
        end else if (load_i) begin
            base_q <= load_state_i;
        end else if (run_i) begin
            base_q <= copies[step_sel_i];
        end
    end

    vsf_tap_pipe #(.COPIES(NUM_COPIES)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .copies_i (copies),
        .sel_i    (step_sel_i),
        .addr_o   (rom_addr)
    );

    vsf_filter_rom u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (rom_addr),
        .bit_o  (ks_bit_o)
    );

    vsf_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .load_i  (load_i),
        .valid_o (ks_valid_o)
    );

endmodule

// File: rtl/vsf_checker.sv
`timescale 1ns/1ps
module vsf_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         run_i,
    input logic         load_i,
    input logic [126:0] load_state_i,
    input logic [126:0] base_q,
    input logic         ks_valid_o
);

    a_r8_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> base_q == $past(load_state_i));

    a_r8_load_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !ks_valid_o);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(base_q));

    a_r6_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !ks_valid_o);

    a_r6_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_valid_o) |-> ($past(run_i) && !$past(load_i)));

    a_r6_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid_o && run_i && !load_i) |=> ks_valid_o);

endmodule

bind varstep_filter_gen vsf_checker i_vsf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .load_i       (load_i),
    .load_state_i (load_state_i),
    .base_q       (base_q),
    .ks_valid_o   (ks_valid_o)
);

// File: tb/test_varstep_filter_gen.sv
`timescale 1ns/1ps
module test_varstep_filter_gen;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_i = 1'b0;
    logic [1:0]   step_sel_i = 2'b00;
    logic         load_i = 1'b0;
    logic [126:0] load_state_i = '0;
    logic         ks_bit_o;
    logic         ks_valid_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [126:0] m_state;
    int           m_cnt;
    logic [31:0]  lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    varstep_filter_gen i_varstep_filter_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .step_sel_i   (step_sel_i),
        .load_i       (load_i),
        .load_state_i (load_state_i),
        .ks_bit_o     (ks_bit_o),
        .ks_valid_o   (ks_valid_o)
    );

    function automatic logic [126:0] shift1(input logic [126:0] s);
        return {s[0] ^ s[1], s[126:1]};
    endfunction

    function automatic logic ref_filter(input logic [126:0] s);
        logic [11:0] a;
        a[0] = s[3];   a[1] = s[11];  a[2] = s[19];  a[3] = s[28];
        a[4] = s[37];  a[5] = s[47];  a[6] = s[58];  a[7] = s[69];
        a[8] = s[80];  a[9] = s[92];  a[10] = s[104]; a[11] = s[118];
        return a[0] ^ a[3] ^ a[6] ^ a[10] ^ (a[1] & a[4]) ^ (a[2] & a[8] & a[11])
             ^ (a[5] & a[7]) ^ (a[9] & ~a[6]);
    endfunction

    function automatic logic [126:0] pattern(input logic [31:0] seed);
        logic [126:0] v;
        logic [31:0]  x = seed;
        for (int i = 0; i < 127; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            v[i] = x[29];
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update model, sample at next negedge
    task automatic cycle(input logic run, input logic ld, input logic [1:0] st,
                         input logic [126:0] val, input string tag);
        logic exp_bit;
        run_i = run; load_i = ld; step_sel_i = st; load_state_i = val;
        exp_bit = ref_filter(m_state);
        if (ld) begin
            m_state = val;
            m_cnt = 0;
        end else if (run) begin
            for (int k = 0; k <= int'(st); k++) m_state = shift1(m_state);
            m_cnt = (m_cnt < 2) ? m_cnt + 1 : 2;
        end else begin
            m_cnt = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, 32'(ks_valid_o), 32'(m_cnt >= 2));
        if (m_cnt >= 2) check({tag, " bit"}, 32'(ks_bit_o), 32'(exp_bit));
    endtask

    function automatic logic [1:0] next_step();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[17:16];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(ks_valid_o), 0);
        check("R1 bit in reset", 32'(ks_bit_o), 0);
        rst_n = 1'b1;
        m_state = 127'd1;
        m_cnt = 0;
        @(negedge clk);
        check("R1 valid after reset", 32'(ks_valid_o), 0);
        check("R1 bit after reset", 32'(ks_bit_o), 0);
    endtask

    // R2 R4 R9 single steps from a loaded value
    task automatic t_single_step();
        cycle(1'b0, 1'b1, 2'b00, pattern(32'h11), "R8 load");
        repeat (40) cycle(1'b1, 1'b0, 2'b00, '0, "R2 R4 R9 single step");
    endtask

    // R3 each fixed step count
    task automatic t_fixed_steps();
        for (int s = 1; s < 4; s++) begin
            cycle(1'b0, 1'b1, 2'b00, pattern(32'h20 + 32'(s)), "R8 load");
            repeat (40) cycle(1'b1, 1'b0, 2'(s), '0, "R3 fixed step");
        end
    endtask

    // R3 R5 step count changing every cycle
    task automatic t_mixed_steps();
        cycle(1'b0, 1'b1, 2'b00, pattern(32'h77), "R8 load");
        repeat (300) cycle(1'b1, 1'b0, next_step(), '0, "R3 R5 mixed step");
    endtask

    // R7 pauses with step input toggling
    task automatic t_pause();
        cycle(1'b0, 1'b1, 2'b00, pattern(32'h5a), "R8 load");
        repeat (10) cycle(1'b1, 1'b0, next_step(), '0, "R7 before pause");
        repeat (5) cycle(1'b0, 1'b0, 2'b11, '0, "R7 paused");
        repeat (20) cycle(1'b1, 1'b0, next_step(), '0, "R7 after pause");
        cycle(1'b0, 1'b0, 2'b10, '0, "R6 one idle cycle");
        repeat (10) cycle(1'b1, 1'b0, next_step(), '0, "R6 refill");
    endtask

    // R8 load together with run and a 4-step command
    task automatic t_load_collision();
        repeat (8) cycle(1'b1, 1'b0, next_step(), '0, "R8 stream");
        cycle(1'b1, 1'b1, 2'b11, pattern(32'h99), "R8 load in stream");
        cycle(1'b1, 1'b0, 2'b11, '0, "R8 fill");
        cycle(1'b1, 1'b1, 2'b11, pattern(32'hab), "R8 load in fill");
        cycle(1'b1, 1'b1, 2'b11, pattern(32'hcd), "R8 back to back load");
        repeat (30) cycle(1'b1, 1'b0, next_step(), '0, "R8 after load");
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_single_step();
        t_fixed_steps();
        t_mixed_steps();
        t_pause();
        t_load_collision();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule